// File: doc/BRIEF.md
# Exception Entry Sequencer

This block sits beside a processor pipeline and decides, once per clock, whether a synchronous exception or an external interrupt is taken. When one is taken, it produces every register update the core needs to enter the handler. The saved copies of status, PC and R15, the new status word, the handler address and the event-code registers all appear together, one clock after the inputs are sampled, with a one-cycle `taken` strobe.

Exceptions always win over interrupts. A status word with the block bit set turns most exceptions into a reset and holds interrupts off, except for a request that wakes the core from sleep. The handler address is picked from the effective event code: a fixed reset address, or the vector base plus one of three offsets. The trap code and the branch-delay-slot case each adjust the saved PC.

All pins are plain level-sampled control and data; there is no stream traffic and no back-pressure. The pipeline holds its request inputs for as long as it wants them considered.

Top module: `exc_entry_seq`

## Requirements
- R1: When `exc_valid` is high, the exception is taken on the next cycle (`taken`=1, `took_irq`=0) whatever `irq_req` shows, and `int_event` keeps its value.
- R2: When status bit 28 (block) is set, a pending exception code other than 0x1E0 is taken as code 0x000; code 0x1E0 is taken unchanged.
- R3: When status bit 28 is set and no exception is pending, an interrupt is taken only if `irq_wake` is high.
- R4: An interrupt is taken only when `irq_level` is strictly greater than status bits 7:4; otherwise nothing is taken.
- R5: On a take, `saved_sr`, `saved_pc` and `saved_r15` get the sampled status, PC and R15, and `new_sr` has bits 28 (block), 29 (bank) and 30 (privileged) set on top of the sampled status.
- R6: With `in_dslot` high on a take, `saved_pc` is the sampled PC minus 2 and `dslot_clear` pulses for that cycle.
- R7: Effective codes 0x000, 0x020 and 0x140 set `new_pc` to 0xA0000000, clear status bit 15 and force bits 7:4 to 0xF in `new_sr`.
- R8: Effective codes 0x040 and 0x060 set `new_pc` to `vbr_in`+0x400; every other exception uses `vbr_in`+0x100.
- R9: Effective code 0x160 adds 2 to `saved_pc` (on top of any R6 adjustment).
- R10: A taken exception writes its effective code to `exc_event` and leaves `int_event`; a taken interrupt writes `irq_code` to `int_event`, sets `new_pc` to `vbr_in`+0x600 and leaves `exc_event`.
- R11: A cycle with nothing taken leaves `taken`, `took_irq` and `dslot_clear` low and every other output unchanged; reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_valid | input | 1 | Synchronous exception pending |
| exc_code | input | CODE_W | Pending exception code |
| irq_req | input | 1 | External interrupt request |
| irq_level | input | 4 | Interrupt priority level |
| irq_code | input | CODE_W | Interrupt event code |
| irq_wake | input | 1 | Request wakes the core from sleep |
| sr_in | input | XLEN | Current status register |
| pc_in | input | XLEN | Current PC |
| r15_in | input | XLEN | Current R15 |
| vbr_in | input | XLEN | Vector base |
| in_dslot | input | 1 | Faulting instruction sits in a delay slot |
| taken | output | 1 | One-cycle strobe: an entry was performed |
| took_irq | output | 1 | The entry was an interrupt |
| dslot_clear | output | 1 | Delay-slot flags must be cleared |
| saved_sr | output | XLEN | Saved status |
| saved_pc | output | XLEN | Saved (return) PC |
| saved_r15 | output | XLEN | Saved R15 |
| new_sr | output | XLEN | Status to load |
| new_pc | output | XLEN | Handler address |
| exc_event | output | CODE_W | Exception event register |
| int_event | output | CODE_W | Interrupt event register |

## Verification
On every cycle the assertions check exception precedence, the reset substitution under the block bit, interrupt suppression by the block bit and by the mask, the mode bits set in the new status, the TLB-miss offset and that idle cycles leave the outputs frozen. The exact saved-PC arithmetic for delay slots combined with the trap code, the reset-class status rewrite and the full level-against-mask grid are shown only by the bench's sweeps, which compare every output against values computed from the requirements.

// File: rtl/eseq_pkg.sv
package eseq_pkg;
  // Status bit positions decoded by the rest of the core
  localparam int SR_BLOCK  = 28;
  localparam int SR_BANK   = 29;
  localparam int SR_PRIV   = 30;
  localparam int SR_FPUOFF = 15;
  localparam int MASK_LO   = 4;
  localparam int MASK_W    = 4;

  // Event codes the sequencer reacts to
  localparam logic [11:0] EV_RESET     = 12'h000;
  localparam logic [11:0] EV_MANRESET  = 12'h020;
  localparam logic [11:0] EV_TLBMISS_R = 12'h040;
  localparam logic [11:0] EV_TLBMISS_W = 12'h060;
  localparam logic [11:0] EV_TLBMULTI  = 12'h140;
  localparam logic [11:0] EV_TRAP      = 12'h160;
  localparam logic [11:0] EV_NOBLOCK   = 12'h1E0;

  // Handler address layout
  localparam logic [31:0] RESET_ADDR   = 32'hA000_0000;
  localparam logic [31:0] OFS_GENERAL  = 32'h0000_0100;
  localparam logic [31:0] OFS_TLB      = 32'h0000_0400;
  localparam logic [31:0] OFS_INTR     = 32'h0000_0600;

  typedef enum logic [1:0] {
    VK_RESET   = 2'd0,
    VK_TLB     = 2'd1,
    VK_GENERAL = 2'd2,
    VK_INTR    = 2'd3
  } vec_kind_e;
endpackage

// File: rtl/eseq_arbiter.sv
module eseq_arbiter
  import eseq_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12
) (
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic [MASK_W-1:0] irq_level,
  input  logic              irq_wake,
  input  logic [XLEN-1:0]   sr,
  output logic              take_exc,
  output logic              take_irq,
  output logic [CODE_W-1:0] eff_code
);
  logic              blocked;
  logic [MASK_W-1:0] cur_mask;
  logic              irq_open;
  logic              irq_above;

  assign blocked   = sr[SR_BLOCK];
  assign cur_mask  = sr[MASK_LO +: MASK_W];
  assign irq_above = irq_level > cur_mask;
  assign irq_open  = !blocked || irq_wake;

  // Exception path: the block bit turns anything but the exempt code into reset
  always_comb begin
    eff_code = exc_code;
    if (blocked && (exc_code != CODE_W'(EV_NOBLOCK)))
      eff_code = CODE_W'(EV_RESET);
  end

  assign take_exc = exc_valid;
  assign take_irq = !exc_valid && irq_req && irq_open && irq_above;
endmodule

// File: rtl/eseq_vector.sv
module eseq_vector
  import eseq_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12
) (
  input  logic              take_irq,
  input  logic [CODE_W-1:0] eff_code,
  input  logic [XLEN-1:0]   sr,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   vbr,
  input  logic              in_dslot,
  output vec_kind_e         kind,
  output logic [XLEN-1:0]   nxt_pc,
  output logic [XLEN-1:0]   nxt_sr,
  output logic [XLEN-1:0]   nxt_spc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(2);

  logic [XLEN-1:0] mode_bits;
  logic [XLEN-1:0] spc_ds;
  logic            is_trap;

  always_comb begin
    mode_bits = '0;
    mode_bits[SR_BLOCK] = 1'b1;
    mode_bits[SR_BANK]  = 1'b1;
    mode_bits[SR_PRIV]  = 1'b1;
  end

  // Handler class from the effective code
  always_comb begin
    if (take_irq)
      kind = VK_INTR;
    else begin
      case (eff_code)
        CODE_W'(EV_RESET), CODE_W'(EV_MANRESET), CODE_W'(EV_TLBMULTI):
          kind = VK_RESET;
        CODE_W'(EV_TLBMISS_R), CODE_W'(EV_TLBMISS_W):
          kind = VK_TLB;
        default:
          kind = VK_GENERAL;
      endcase
    end
  end

  // Return address: rewind into the branch, then step over a trap
  assign is_trap = !take_irq && (eff_code == CODE_W'(EV_TRAP));
  assign spc_ds  = in_dslot ? (pc - STEP) : pc;
  assign nxt_spc = is_trap ? (spc_ds + STEP) : spc_ds;

  always_comb begin
    nxt_sr = sr | mode_bits;
    nxt_pc = vbr + XLEN'(OFS_GENERAL);
    unique case (kind)
      VK_RESET: begin
        nxt_sr[SR_FPUOFF] = 1'b0;
        nxt_sr[MASK_LO +: MASK_W] = '1;
        nxt_pc = XLEN'(RESET_ADDR);
      end
      VK_TLB:     nxt_pc = vbr + XLEN'(OFS_TLB);
      VK_INTR:    nxt_pc = vbr + XLEN'(OFS_INTR);
      VK_GENERAL: nxt_pc = vbr + XLEN'(OFS_GENERAL);
    endcase
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import eseq_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic [3:0]        irq_level,
  input  logic [CODE_W-1:0] irq_code,
  input  logic              irq_wake,
  input  logic [XLEN-1:0]   sr_in,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   r15_in,
  input  logic [XLEN-1:0]   vbr_in,
  input  logic              in_dslot,
  output logic              taken,
  output logic              took_irq,
  output logic              dslot_clear,
  output logic [XLEN-1:0]   saved_sr,
  output logic [XLEN-1:0]   saved_pc,
  output logic [XLEN-1:0]   saved_r15,
  output logic [XLEN-1:0]   new_sr,
  output logic [XLEN-1:0]   new_pc,
  output logic [CODE_W-1:0] exc_event,
  output logic [CODE_W-1:0] int_event
);
  logic              take_exc, take_irq, take_any;
  logic [CODE_W-1:0] eff_code;
  vec_kind_e         kind;
  logic [XLEN-1:0]   nxt_pc, nxt_sr, nxt_spc;

  eseq_arbiter #(.XLEN(XLEN), .CODE_W(CODE_W)) u_arb (
    .exc_valid (exc_valid),
    .exc_code  (exc_code),
    .irq_req   (irq_req),
    .irq_level (irq_level),
    .irq_wake  (irq_wake),
    .sr        (sr_in),
    .take_exc  (take_exc),
    .take_irq  (take_irq),
    .eff_code  (eff_code)
  );

  eseq_vector #(.XLEN(XLEN), .CODE_W(CODE_W)) u_vec (
    .take_irq (take_irq),
    .eff_code (eff_code),
    .sr       (sr_in),
    .pc       (pc_in),
    .vbr      (vbr_in),
    .in_dslot (in_dslot),
    .kind     (kind),
    .nxt_pc   (nxt_pc),
    .nxt_sr   (nxt_sr),
    .nxt_spc  (nxt_spc)
  );

  assign take_any = take_exc || take_irq;

  // Strobes: high only in the cycle after a take
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken       <= 1'b0;
      took_irq    <= 1'b0;
      dslot_clear <= 1'b0;
    end else begin
      taken       <= take_any;
      took_irq    <= take_irq;
      dslot_clear <= take_any && in_dslot;
    end
  end

  // Architectural state: all updated together, held otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saved_sr  <= '0;
      saved_pc  <= '0;
      saved_r15 <= '0;
      new_sr    <= '0;
      new_pc    <= '0;
    end else if (take_any) begin
      saved_sr  <= sr_in;
      saved_pc  <= nxt_spc;
      saved_r15 <= r15_in;
      new_sr    <= nxt_sr;
      new_pc    <= nxt_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_event <= '0;
      int_event <= '0;
    end else begin
      if (take_exc) exc_event <= eff_code;
      if (take_irq) int_event <= irq_code;
    end
  end

  AST_EXC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (taken && !took_irq && $stable(int_event))) else $error("AST_EXC_FIRST"); // R1

  AST_BLOCK_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && sr_in[SR_BLOCK] && (exc_code != CODE_W'(EV_NOBLOCK)))
      |=> (exc_event == CODE_W'(EV_RESET))) else $error("AST_BLOCK_RESET"); // R2

  AST_BLOCK_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_valid && sr_in[SR_BLOCK] && !irq_wake) |=> !taken) else $error("AST_BLOCK_IRQ"); // R3

  AST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_valid && (irq_level <= sr_in[MASK_LO +: MASK_W])) |=> !taken) else $error("AST_MASKED"); // R4

  AST_MODE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> (new_sr[SR_BLOCK] && new_sr[SR_BANK] && new_sr[SR_PRIV])) else $error("AST_MODE_BITS"); // R5

  AST_TLB_OFS: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !sr_in[SR_BLOCK] &&
     ((exc_code == CODE_W'(EV_TLBMISS_R)) || (exc_code == CODE_W'(EV_TLBMISS_W))))
      |=> (new_pc == $past(vbr_in) + XLEN'(OFS_TLB))) else $error("AST_TLB_OFS"); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_valid && !irq_req) |=> (!taken && !dslot_clear && $stable(new_pc) &&
                                  $stable(saved_pc) && $stable(exc_event))) else $error("AST_IDLE_HOLD"); // R11
endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
  localparam int XLEN = 32;
  localparam int CODE_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exc_valid = 0, irq_req = 0, irq_wake = 0, in_dslot = 0;
  logic [CODE_W-1:0] exc_code = '0, irq_code = '0;
  logic [3:0] irq_level = '0;
  logic [XLEN-1:0] sr_in = '0, pc_in = '0, r15_in = '0, vbr_in = '0;
  logic taken, took_irq, dslot_clear;
  logic [XLEN-1:0] saved_sr, saved_pc, saved_r15, new_sr, new_pc;
  logic [CODE_W-1:0] exc_event, int_event;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_entry_seq #(.XLEN(XLEN), .CODE_W(CODE_W)) uut (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
    .irq_req(irq_req), .irq_level(irq_level), .irq_code(irq_code), .irq_wake(irq_wake),
    .sr_in(sr_in), .pc_in(pc_in), .r15_in(r15_in), .vbr_in(vbr_in), .in_dslot(in_dslot),
    .taken(taken), .took_irq(took_irq), .dslot_clear(dslot_clear),
    .saved_sr(saved_sr), .saved_pc(saved_pc), .saved_r15(saved_r15),
    .new_sr(new_sr), .new_pc(new_pc), .exc_event(exc_event), .int_event(int_event)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus: drive at negedge, sample at the following negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_idle();
    exc_valid = 0; irq_req = 0; irq_wake = 0; in_dslot = 0;
  endtask

  logic [11:0] codes [10] = '{12'h000, 12'h020, 12'h040, 12'h060, 12'h0A0,
                              12'h0C0, 12'h140, 12'h160, 12'h180, 12'h1E0};

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "taken after reset", 32'(taken), 0);
    chk("R11", "new_pc after reset", new_pc, 0);
    chk("R11", "exc_event after reset", 32'(exc_event), 0);
    rst_n = 1;
    @(negedge clk);

    // Exception sweep: every code, block bit, delay slot
    for (int ci = 0; ci < 10; ci++) begin
      for (int bl = 0; bl < 2; bl++) begin
        for (int ds = 0; ds < 2; ds++) begin
          logic [11:0] ec;
          logic [31:0] esr, epc, espc, ebase;
          int iev_before;
          ebase = 32'h8C00_0000 + 32'(ci) * 32'h1000;
          sr_in  = 32'h0000_8035 | (32'(bl) << 28);
          pc_in  = 32'h0C00_1000 + 32'(ci * 16 + bl * 4 + ds);
          r15_in = 32'h7000_0000 + 32'(ci);
          vbr_in = ebase;
          exc_code = codes[ci];
          exc_valid = 1; in_dslot = ds[0];
          irq_req = 1; irq_level = 4'hF; irq_code = 12'h3C0; // competes, must lose
          iev_before = int'(int_event);
          ec = (bl == 1 && codes[ci] != 12'h1E0) ? 12'h000 : codes[ci];
          espc = pc_in - (ds == 1 ? 32'd2 : 32'd0) + (ec == 12'h160 ? 32'd2 : 32'd0);
          esr = sr_in | 32'h7000_0000;
          if (ec == 12'h000 || ec == 12'h020 || ec == 12'h140) begin
            esr = (esr & ~32'h0000_80F0) | 32'h0000_00F0;
            epc = 32'hA000_0000;
          end else if (ec == 12'h040 || ec == 12'h060) epc = ebase + 32'h400;
          else epc = ebase + 32'h100;
          step();
          chk("R1", "taken", 32'(taken), 1);
          chk("R1", "took_irq", 32'(took_irq), 0);
          chk("R1", "int_event kept", 32'(int_event), 32'(iev_before));
          chk("R2", "exc_event", 32'(exc_event), 32'(ec));
          chk("R5", "saved_sr", saved_sr, sr_in);
          chk("R5", "saved_r15", saved_r15, r15_in);
          chk("R6", "dslot_clear", 32'(dslot_clear), 32'(ds));
          chk("R9", "saved_pc", saved_pc, espc);
          chk("R7", "new_sr", new_sr, esr);
          chk("R8", "new_pc", new_pc, epc);
          go_idle();
          step();
          // R11: idle cycle changes nothing
          chk("R11", "taken idle", 32'(taken), 0);
          chk("R11", "dslot_clear idle", 32'(dslot_clear), 0);
          chk("R11", "new_pc held", new_pc, epc);
          chk("R11", "saved_pc held", saved_pc, espc);
          chk("R11", "exc_event held", 32'(exc_event), 32'(ec));
        end
      end
    end

    // Interrupt sweep: level x mask x block x wake
    for (int m = 0; m < 16; m++) begin
      for (int lv = 0; lv < 16; lv++) begin
        for (int bw = 0; bw < 4; bw++) begin
          logic expt;
          logic [31:0] prev_pc;
          logic [11:0] prev_iev, prev_eev, code;
          int bl, wk;
          bl = bw >> 1; wk = bw & 1;
          code = 12'h200 + 12'(m * 16 + lv);
          prev_pc = new_pc; prev_iev = int_event; prev_eev = exc_event;
          sr_in = (32'(m) << 4) | (32'(bl) << 28);
          pc_in = 32'h0C00_4000 + 32'(lv);
          vbr_in = 32'h8800_0000 + 32'(m) * 32'h100;
          irq_req = 1; irq_level = 4'(lv); irq_code = code; irq_wake = wk[0];
          expt = (lv > m) && (bl == 0 || wk == 1);
          step();
          if (expt) begin
            chk("R4", "irq taken", 32'(taken), 1);
            chk("R10", "took_irq", 32'(took_irq), 1);
            chk("R10", "int_event", 32'(int_event), 32'(code));
            chk("R10", "exc_event kept", 32'(exc_event), 32'(prev_eev));
            chk("R10", "irq new_pc", new_pc, vbr_in + 32'h600);
            chk("R5", "irq saved_pc", saved_pc, pc_in);
          end else begin
            chk(bl == 1 ? "R3" : "R4", "irq not taken", 32'(taken), 0);
            chk("R11", "new_pc held on reject", new_pc, prev_pc);
            chk("R11", "int_event held on reject", 32'(int_event), 32'(prev_iev));
          end
          go_idle();
          step();
        end
      end
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule